// File: doc/BRIEF.md
# Dual-Format Serial Display Link Master

This block is the host end of a serial link to a display controller. A static two-bit format input picks one of two frame layouts. In the 3-line layout every transaction is a 9-bit frame: its first bit tells the display whether the byte is a command or data, and the byte follows. In the 4-line layout the frame is 8 bits long, and a separate data/command output carries the flag for the whole time chip select is low. The other two codes of the format input stand for parallel buses, and the block leaves them alone.

The system side offers one byte per transaction on a valid/ready handshake, together with a command/data flag and a read/write flag. A write shifts the byte out on the serial output line. A read drives the clock and collects eight bits from the display's return line, then hands the byte back with a one-cycle done pulse. Reads run on a much slower serial clock and use longer chip-select setup and hold than writes. Each of these is set by its own cycle-count parameter. After every frame, chip select stays high for a minimum recovery gap.

Top module: `lcd_ser_master`

## Requirements
- R1: Only format codes 2'b01 (3-line, 9-bit frame) and 2'b11 (4-line, 8-bit frame) are served. With 2'b00 or 2'b10, reqReady stays 0, no request is taken and csN stays 1.
- R2: In 3-line format, frame bit 0 on sdo is the flag (1 = data, 0 = command). Bits 1 to 8 are the byte, MSB first, for a write, or 0 for a read.
- R3: In 4-line format, sdo carries the byte MSB first over 8 bits, or 0 for a read. While csN is low, dcx equals the flag (1 = data) and does not change. In 3-line format, dcx is 1 while csN is low.
- R4: sclk is 0 whenever csN is 1. Each high phase and each low phase lasts WR_HALF cycles on a write and RD_HALF cycles on a read. sdo changes only while sclk is low, so it is stable through every high phase.
- R5: csN falls and first-bit data appears WR_CSS (write) or RD_CSS (read) cycles before sclk first rises. csN stays low for WR_CSH or RD_CSH cycles after sclk last falls.
- R6: After csN rises, it stays high and reqReady stays 0 for GAP cycles. reqReady then returns to 1.
- R7: A read samples sdi at the first clock edge of each high phase that carries a data bit (every bit in 4-line format, bits 1 to 8 in 3-line format), MSB first. rdByte is presented with a single-cycle rdDone in the first cycle after csN rises, and it holds its value until the next read completes.
- R8: A request is taken only on a cycle where reqValid and reqReady are both 1, and its flags and byte are captured at that moment. Changes to reqIsData, reqIsRead or reqByte during a frame have no effect on it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| fmtSel | input | 2 | Static format select: 01 = 3-line, 11 = 4-line |
| reqValid | input | 1 | Request offered |
| reqReady | output | 1 | Request can be taken |
| reqIsData | input | 1 | 1 = data, 0 = command |
| reqIsRead | input | 1 | 1 = read from display, 0 = write |
| reqByte | input | 8 | Byte to write |
| rdDone | output | 1 | One-cycle pulse: read byte valid |
| rdByte | output | 8 | Byte returned by the last read |
| csN | output | 1 | Chip select, active low |
| sclk | output | 1 | Serial clock, idles low |
| sdo | output | 1 | Serial line toward the display |
| dcx | output | 1 | Data/command line for 4-line format |
| sdi | input | 1 | Serial line from the display |

## Verification
The case that is hardest to reach from the ports is a read whose returned bits must match sample points that fall deep inside a slow high phase, with the read clock, the flag bit in the 3-line frame and the extended hold all in play. The bench includes a small display model that changes sdi only after each falling sclk edge and puts the bit pattern it expects on the line. Because of this, a sample taken on the wrong bit or at the wrong phase shows up as a wrong rdByte. Back-to-back requests are held on reqValid to reach the gap boundary exactly. Flags and the byte are scrambled mid-frame so that a late capture would show on sdo or dcx.

// File: rtl/lcd_ser_pkg.sv
package lcd_ser_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_SETUP,
    ST_HIGH,
    ST_LOW,
    ST_HOLD,
    ST_GAP
  } linkState_e;

  // strobes from control to datapath, one clock each
  typedef struct packed {
    logic load;      // capture a new request and first frame bit
    logic shiftOut;  // advance outgoing frame by one bit
    logic sampleIn;  // take sdi into the receive register
    logic finish;    // frame over, publish read result
  } dpCtl_t;

  localparam logic [1:0] FMT_3LINE = 2'b01;
  localparam logic [1:0] FMT_4LINE = 2'b11;

  function automatic logic fmtServed(input logic [1:0] f);
    return (f == FMT_3LINE) || (f == FMT_4LINE);
  endfunction

endpackage

// File: rtl/lcd_ser_ctrl.sv
module lcd_ser_ctrl
  import lcd_ser_pkg::*;
#(
  parameter int WR_HALF = 1,
  parameter int RD_HALF = 10,
  parameter int WR_CSS  = 2,
  parameter int WR_CSH  = 2,
  parameter int RD_CSS  = 8,
  parameter int RD_CSH  = 9,
  parameter int GAP     = 5
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic [1:0] fmtSel,
  input  logic       reqValid,
  input  logic       reqIsRead,
  output logic       reqReady,
  output logic       csN,
  output logic       sclk,
  output dpCtl_t     ctl
);

  localparam int M1 = (WR_HALF > RD_HALF) ? WR_HALF : RD_HALF;
  localparam int M2 = (WR_CSS > RD_CSS) ? WR_CSS : RD_CSS;
  localparam int M3 = (WR_CSH > RD_CSH) ? WR_CSH : RD_CSH;
  localparam int M4 = (M1 > M2) ? M1 : M2;
  localparam int M5 = (M3 > GAP) ? M3 : GAP;
  localparam int MAXT = (M4 > M5) ? M4 : M5;
  localparam int TW = $clog2(MAXT + 1);
  localparam int BW = 4;

  linkState_e state;
  logic [TW-1:0] tmr;
  logic [BW-1:0] bitCnt;
  logic          rdLat;
  logic          threeLat;

  logic          accept;
  logic          lastBit;
  logic [TW-1:0] halfTop;
  logic [TW-1:0] holdTop;
  logic [TW-1:0] setupTop;
  logic          dataBit;

  always_comb begin
    reqReady = (state == ST_IDLE) && fmtServed(fmtSel);
    accept   = reqReady && reqValid;
    halfTop  = rdLat ? TW'(RD_HALF - 1) : TW'(WR_HALF - 1);
    holdTop  = rdLat ? TW'(RD_CSH - 1) : TW'(WR_CSH - 1);
    setupTop = reqIsRead ? TW'(RD_CSS - 1) : TW'(WR_CSS - 1);
    lastBit  = bitCnt == (threeLat ? BW'(8) : BW'(7));
    dataBit  = !threeLat || (bitCnt != '0);
    csN      = !((state == ST_SETUP) || (state == ST_HIGH) ||
                 (state == ST_LOW) || (state == ST_HOLD));
    sclk     = (state == ST_HIGH);
  end

  always_comb begin
    ctl          = '0;
    ctl.load     = accept;
    ctl.shiftOut = (state == ST_HIGH) && (tmr == '0) && !lastBit;
    ctl.sampleIn = (state == ST_HIGH) && (tmr == halfTop) && rdLat && dataBit;
    ctl.finish   = (state == ST_HOLD) && (tmr == '0);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state    <= ST_IDLE;
      tmr      <= '0;
      bitCnt   <= '0;
      rdLat    <= 1'b0;
      threeLat <= 1'b0;
    end else begin
      unique case (state)
        ST_IDLE: begin
          if (accept) begin
            state    <= ST_SETUP;
            tmr      <= setupTop;
            bitCnt   <= '0;
            rdLat    <= reqIsRead;
            threeLat <= (fmtSel == FMT_3LINE);
          end
        end
        ST_SETUP: begin
          if (tmr == '0) begin
            state <= ST_HIGH;
            tmr   <= halfTop;
          end else begin
            tmr <= tmr - 1'b1;
          end
        end
        ST_HIGH: begin
          if (tmr != '0) begin
            tmr <= tmr - 1'b1;
          end else if (lastBit) begin
            state <= ST_HOLD;
            tmr   <= holdTop;
          end else begin
            state  <= ST_LOW;
            tmr    <= halfTop;
            bitCnt <= bitCnt + 1'b1;
          end
        end
        ST_LOW: begin
          if (tmr == '0) begin
            state <= ST_HIGH;
            tmr   <= halfTop;
          end else begin
            tmr <= tmr - 1'b1;
          end
        end
        ST_HOLD: begin
          if (tmr == '0) begin
            state <= ST_GAP;
            tmr   <= TW'(GAP - 1);
          end else begin
            tmr <= tmr - 1'b1;
          end
        end
        ST_GAP: begin
          if (tmr == '0) state <= ST_IDLE;
          else tmr <= tmr - 1'b1;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/lcd_ser_dp.sv
module lcd_ser_dp
  import lcd_ser_pkg::*;
#(
  parameter int BYTE_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  dpCtl_t            ctl,
  input  logic [1:0]        fmtSel,
  input  logic              reqIsData,
  input  logic              reqIsRead,
  input  logic [BYTE_W-1:0] reqByte,
  input  logic              sdi,
  output logic              sdo,
  output logic              dcx,
  output logic              rdDone,
  output logic [BYTE_W-1:0] rdByte
);

  localparam int FW = BYTE_W + 1;

  logic [FW-1:0]     txSr;
  logic [BYTE_W-1:0] rxSr;
  logic              rdLat;
  logic [BYTE_W-1:0] payload;

  always_comb payload = reqIsRead ? '0 : reqByte;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      txSr  <= '0;
      dcx   <= 1'b1;
      rdLat <= 1'b0;
    end else if (ctl.load) begin
      rdLat <= reqIsRead;
      if (fmtSel == FMT_3LINE) begin
        txSr <= {reqIsData, payload};
        dcx  <= 1'b1;
      end else begin
        txSr <= {payload, 1'b0};
        dcx  <= reqIsData;
      end
    end else if (ctl.shiftOut) begin
      txSr <= {txSr[FW-2:0], 1'b0};
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rxSr   <= '0;
      rdByte <= '0;
      rdDone <= 1'b0;
    end else begin
      rdDone <= ctl.finish && rdLat;
      if (ctl.sampleIn) rxSr <= {rxSr[BYTE_W-2:0], sdi};
      if (ctl.finish && rdLat) rdByte <= rxSr;
    end
  end

  assign sdo = txSr[FW-1];

endmodule

// File: rtl/lcd_ser_master.sv
module lcd_ser_master
  import lcd_ser_pkg::*;
#(
  parameter int WR_HALF = 1,
  parameter int RD_HALF = 10,
  parameter int WR_CSS  = 2,
  parameter int WR_CSH  = 2,
  parameter int RD_CSS  = 8,
  parameter int RD_CSH  = 9,
  parameter int GAP     = 5
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic [1:0] fmtSel,
  input  logic       reqValid,
  output logic       reqReady,
  input  logic       reqIsData,
  input  logic       reqIsRead,
  input  logic [7:0] reqByte,
  output logic       rdDone,
  output logic [7:0] rdByte,
  output logic       csN,
  output logic       sclk,
  output logic       sdo,
  output logic       dcx,
  input  logic       sdi
);

  dpCtl_t ctl;

  lcd_ser_ctrl #(
    .WR_HALF(WR_HALF), .RD_HALF(RD_HALF),
    .WR_CSS(WR_CSS), .WR_CSH(WR_CSH),
    .RD_CSS(RD_CSS), .RD_CSH(RD_CSH),
    .GAP(GAP)
  ) u_ctrl (
    .clk(clk), .rstN(rstN), .fmtSel(fmtSel),
    .reqValid(reqValid), .reqIsRead(reqIsRead),
    .reqReady(reqReady), .csN(csN), .sclk(sclk), .ctl(ctl)
  );

  lcd_ser_dp #(.BYTE_W(8)) u_dp (
    .clk(clk), .rstN(rstN), .ctl(ctl), .fmtSel(fmtSel),
    .reqIsData(reqIsData), .reqIsRead(reqIsRead), .reqByte(reqByte),
    .sdi(sdi), .sdo(sdo), .dcx(dcx), .rdDone(rdDone), .rdByte(rdByte)
  );

endmodule

// File: rtl/lcd_ser_chk.sv
module lcd_ser_chk (
  input logic       clk,
  input logic       rstN,
  input logic [1:0] fmtSel,
  input logic       reqReady,
  input logic       rdDone,
  input logic       csN,
  input logic       sclk,
  input logic       sdo,
  input logic       dcx
);

  // R1: parallel codes never offer readiness
  p_no_parallel_r1: assert property (@(posedge clk) disable iff (!rstN)
    (fmtSel[0] == 1'b0) |-> !reqReady);

  // R4: clock parked low outside a frame
  p_sclk_idle_low_r4: assert property (@(posedge clk) disable iff (!rstN)
    csN |-> !sclk);

  // R4: outgoing bit steady across a high phase
  p_sdo_steady_high_r4: assert property (@(posedge clk) disable iff (!rstN)
    (sclk && $past(sclk)) |-> $stable(sdo));

  // R3: data/command line steady while selected
  p_dcx_steady_r3: assert property (@(posedge clk) disable iff (!rstN)
    (!csN && $past(!csN)) |-> $stable(dcx));

  // R5: selection starts with the clock low
  p_cs_fall_clk_low_r5: assert property (@(posedge clk) disable iff (!rstN)
    $fell(csN) |-> !sclk);

  // R6: ready only while deselected
  p_ready_deselected_r6: assert property (@(posedge clk) disable iff (!rstN)
    reqReady |-> csN);

  // R7: done lasts one cycle
  p_done_single_r7: assert property (@(posedge clk) disable iff (!rstN)
    rdDone |=> !rdDone);

  // R6: no immediate reselect after release
  p_gap_hold_r6: assert property (@(posedge clk) disable iff (!rstN)
    $rose(csN) |=> csN);

endmodule

bind lcd_ser_master lcd_ser_chk u_chk (
  .clk(clk), .rstN(rstN), .fmtSel(fmtSel), .reqReady(reqReady),
  .rdDone(rdDone), .csN(csN), .sclk(sclk), .sdo(sdo), .dcx(dcx)
);

// File: tb/sim_lcd_ser_master.sv
module sim_lcd_ser_master;

  localparam int WH = 1, RH = 10, WCSS = 2, WCSH = 2, RCSS = 8, RCSH = 9, GP = 5;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [1:0] fmtSel = 2'b01;
  logic reqValid = 1'b0, reqIsData = 1'b0, reqIsRead = 1'b0;
  logic [7:0] reqByte = 8'h00;
  logic sdi = 1'b0;
  logic reqReady, rdDone, csN, sclk, sdo, dcx;
  logic [7:0] rdByte;

  always #4 clk = ~clk;  // 125 MHz

  lcd_ser_master #(
    .WR_HALF(WH), .RD_HALF(RH), .WR_CSS(WCSS), .WR_CSH(WCSH),
    .RD_CSS(RCSS), .RD_CSH(RCSH), .GAP(GP)
  ) u0 (
    .clk(clk), .rstN(rstN), .fmtSel(fmtSel), .reqValid(reqValid),
    .reqReady(reqReady), .reqIsData(reqIsData), .reqIsRead(reqIsRead),
    .reqByte(reqByte), .rdDone(rdDone), .rdByte(rdByte), .csN(csN),
    .sclk(sclk), .sdo(sdo), .dcx(dcx), .sdi(sdi)
  );

  typedef struct {
    logic cs, ck, so, dc, rdy, dn;
    logic chkSo, chkDc;
    logic [7:0] rb;
  } exp_t;

  exp_t expQ[$];
  int vectors = 0;
  int miscompares = 0;
  logic [7:0] rdPat = 8'h00;
  int frameBit = 0;
  logic running = 1'b0;

  // display model: next bit appears after each falling clock
  function automatic logic patBit(input int j);
    int off;
    off = (fmtSel == 2'b01) ? 1 : 0;
    if (j < off || j - off > 7) return 1'b0;
    return rdPat[7 - (j - off)];
  endfunction

  always @(negedge csN) begin
    frameBit = 0;
    #1 sdi = patBit(0);
  end
  always @(negedge sclk) if (!csN) begin
    frameBit = frameBit + 1;
    #1 sdi = patBit(frameBit);
  end

  task automatic pushRec(input logic cs, input logic ck, input logic so,
                         input logic dc, input logic dn, input logic chk,
                         input logic [7:0] rb);
    exp_t e;
    e.cs = cs; e.ck = ck; e.so = so; e.dc = dc; e.rdy = 1'b0; e.dn = dn;
    e.chkSo = chk; e.chkDc = chk; e.rb = rb;
    expQ.push_back(e);
  endtask

  // builds the expected per-cycle picture of one frame from the requirements
  task automatic pushFrame(input logic isData, input logic isRead,
                           input logic [7:0] b, input logic three);
    logic fb[9];
    int len, h, css, csh;
    logic dcExp;
    len = three ? 9 : 8;
    h   = isRead ? RH : WH;
    css = isRead ? RCSS : WCSS;
    csh = isRead ? RCSH : WCSH;
    dcExp = three ? 1'b1 : isData;
    for (int i = 0; i < 9; i++) fb[i] = 1'b0;
    if (three) begin
      fb[0] = isData;
      for (int i = 0; i < 8; i++) fb[i+1] = isRead ? 1'b0 : b[7-i];
    end else begin
      for (int i = 0; i < 8; i++) fb[i] = isRead ? 1'b0 : b[7-i];
    end
    for (int c = 0; c < css; c++) pushRec(0, 0, fb[0], dcExp, 0, 1, 8'h00);
    for (int i = 0; i < len; i++) begin
      for (int c = 0; c < h; c++) pushRec(0, 1, fb[i], dcExp, 0, 1, 8'h00);
      if (i < len - 1)
        for (int c = 0; c < h; c++) pushRec(0, 0, fb[i+1], dcExp, 0, 1, 8'h00);
    end
    for (int c = 0; c < csh; c++) pushRec(0, 0, fb[len-1], dcExp, 0, 1, 8'h00);
    for (int c = 0; c < GP; c++) pushRec(1, 0, 1'b0, 1'b1, (c == 0) && isRead, 0, rdPat);
  endtask

  exp_t cur;
  logic bad;

  always @(negedge clk) if (running) begin
    if (expQ.size() > 0) cur = expQ.pop_front();
    else begin
      cur.cs = 1; cur.ck = 0; cur.so = 0; cur.dc = 1; cur.dn = 0;
      cur.rdy = fmtSel[0]; cur.chkSo = 0; cur.chkDc = 0; cur.rb = 8'h00;
    end
    vectors++;
    bad = 1'b0;
    if (csN !== cur.cs) begin
      bad = 1; $display("FAIL R5 csN act=%b exp=%b t=%0t", csN, cur.cs, $time);
    end
    if (sclk !== cur.ck) begin
      bad = 1; $display("FAIL R4 sclk act=%b exp=%b t=%0t", sclk, cur.ck, $time);
    end
    if (cur.chkSo && sdo !== cur.so) begin
      bad = 1;
      if (fmtSel == 2'b01) $display("FAIL R2 sdo act=%b exp=%b t=%0t", sdo, cur.so, $time);
      else $display("FAIL R3 sdo act=%b exp=%b t=%0t", sdo, cur.so, $time);
    end
    if (cur.chkDc && dcx !== cur.dc) begin
      bad = 1; $display("FAIL R3 dcx act=%b exp=%b t=%0t", dcx, cur.dc, $time);
    end
    if (reqReady !== cur.rdy) begin
      bad = 1;
      if (!fmtSel[0]) $display("FAIL R1 reqReady act=%b exp=%b t=%0t", reqReady, cur.rdy, $time);
      else $display("FAIL R6 reqReady act=%b exp=%b t=%0t", reqReady, cur.rdy, $time);
    end
    if (!fmtSel[0] && csN !== 1'b1) begin
      bad = 1; $display("FAIL R1 csN act=%b exp=1 t=%0t", csN, $time);
    end
    if (rdDone !== cur.dn) begin
      bad = 1; $display("FAIL R7 rdDone act=%b exp=%b t=%0t", rdDone, cur.dn, $time);
    end
    if (cur.dn && rdByte !== cur.rb) begin
      bad = 1; $display("FAIL R7 rdByte act=%h exp=%h t=%0t", rdByte, cur.rb, $time);
    end
    if (bad) miscompares++;
    // R8: capture happens only on a valid and ready cycle
    if (reqValid && reqReady) pushFrame(reqIsData, reqIsRead, reqByte, fmtSel == 2'b01);
  end

  // issue one request, then scramble the fields while the frame runs (R8)
  task automatic send(input logic isData, input logic isRead, input logic [7:0] b);
    @(posedge clk); #2;
    reqIsData = isData; reqIsRead = isRead; reqByte = b; reqValid = 1'b1;
    do @(negedge clk); while (!reqReady);
    @(posedge clk); #2;
    reqValid = 1'b0; reqIsData = ~isData; reqIsRead = ~isRead; reqByte = ~b;
  endtask

  task automatic drain();
    do @(posedge clk); while (expQ.size() > 0);
    repeat (3) @(posedge clk);
  endtask

  task automatic finishRun();
    $display("  == %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  endtask

  initial begin
    #(8 * 150000);
    miscompares++;
    $display("FAIL watchdog expired act=running exp=finished");
    finishRun();
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    // reset state: deselected, clock low, no done (R4 R5 R7)
    vectors++;
    if (csN !== 1'b1 || sclk !== 1'b0 || rdDone !== 1'b0) begin
      miscompares++;
      $display("FAIL R5 reset csN/sclk/rdDone act=%b%b%b exp=100", csN, sclk, rdDone);
    end
    @(posedge clk); #2;
    rstN = 1'b1;
    running = 1'b1;
    repeat (2) @(posedge clk);

    // R2: 3-line writes, command and data
    fmtSel = 2'b01;
    send(1'b0, 1'b0, 8'hA5);
    send(1'b1, 1'b0, 8'h3C);
    drain();
    // R7: 3-line reads with distinct patterns
    rdPat = 8'hC3; send(1'b1, 1'b1, 8'hFF); drain();
    rdPat = 8'h5A; send(1'b0, 1'b1, 8'h00); drain();

    // R3: 4-line writes and reads
    fmtSel = 2'b11;
    send(1'b0, 1'b0, 8'h81);
    send(1'b1, 1'b0, 8'h7E);
    drain();
    rdPat = 8'h96; send(1'b1, 1'b1, 8'h12); drain();
    rdPat = 8'h01; send(1'b0, 1'b1, 8'hEE); drain();

    // R6: back-to-back requests held valid across the gap
    @(posedge clk); #2;
    reqIsData = 1'b1; reqIsRead = 1'b0; reqByte = 8'hF0; reqValid = 1'b1;
    repeat (60) @(posedge clk);
    #2 reqValid = 1'b0;
    drain();

    // R1: parallel codes rejected while a request is held
    fmtSel = 2'b00;
    @(posedge clk); #2 reqValid = 1'b1;
    repeat (20) @(posedge clk);
    #2 fmtSel = 2'b10;
    repeat (20) @(posedge clk);
    #2 reqValid = 1'b0; fmtSel = 2'b01;
    repeat (3) @(posedge clk);

    // R7: rdByte holds across a following write
    rdPat = 8'hB4; send(1'b1, 1'b1, 8'h00);
    send(1'b1, 1'b0, 8'h11);
    drain();
    vectors++;
    if (rdByte !== 8'hB4) begin
      miscompares++;
      $display("FAIL R7 rdByte hold act=%h exp=b4", rdByte);
    end

    finishRun();
  end

endmodule